// File: doc/BRIEF.md
# CPU Register Port for a Raster Display Controller

This block sits between an 8-bit microprocessor bus and the configuration registers of a raster display timing generator. The processor reaches every internal register indirectly: it first writes a register number into an index register, then reads or writes the data location that the index points at. The same select value that loads the index on a write returns a status byte on a read. The status byte reports whether vertical retrace is in progress, so software can time its accesses to video memory.

The block also latches the live refresh address into a light pen register whenever the pen input rises. The pen input comes from outside the clock domain, so it is synchronized before its rising edge is detected. The register map is fixed in this order:
- indexes 0 to NUM_CFG-1 are write-only timing registers, presented on a flat bus;
- the next two indexes hold the cursor address (high part first), which can be read and written;
- the two after those return the captured pen address (high part first) and are read-only.

The pad is modelled as a separate input bus, output bus and output enable.

Top module: `crtc_cpu_port`

## Requirements
- R1: While `cs_n` is high, no register changes on any strobe, and `dout_oe` stays low.
- R2: `dout_oe` is high only when `cs_n` is low, `rw` is high (read) and `en` is high. While `dout_oe` is low, `dout` is all zeros.
- R3: A write with `rs` low loads the index register from the low IDX_W bits of `din`, so 8'h2E selects index 14.
- R4: A read with `rs` low returns the status byte: bit 5 equals `vretrace` and all other bits are 0.
- R5: A write with `rs` high to index k < NUM_CFG stores `din` into field `cfg_regs[k*8 +: 8]`. Reading such an index returns 0.
- R6: A write is taken once, on the first clock at which `en` is high after being low. Holding `en` high, or changing `din` while it is held high, has no further effect. `en` may stay idle for any length of time.
- R7: Index NUM_CFG holds the cursor high part (6 bits; bits 7:6 read as 0) and index NUM_CFG+1 holds the cursor low part. Both can be read back, and `cursor_addr` = {high, low}.
- R8: A low-to-high transition on `pen` latches `refresh_addr` into the pen register. The value latched is the one present two clock edges after the first edge that samples `pen` high. Index NUM_CFG+2 reads bits 13:8 (zero-extended) and index NUM_CFG+3 reads bits 7:0.
- R9: A steady or falling `pen` leaves the pen register unchanged, even if `refresh_addr` changes.
- R10: Writes to the two pen indexes, or to any index at or above NUM_CFG+4, change nothing. Reads of undefined indexes return 0.
- R11: While `rst_n` is low, the index, all registers and the pen register are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 0: index/status, 1: indexed data register |
| rw | input | 1 | 1: read, 0: write |
| en | input | 1 | Transfer strobe, active high |
| din | input | DW | Write data from the processor |
| dout | output | DW | Read data to the processor |
| dout_oe | output | 1 | Output enable for the data pad |
| vretrace | input | 1 | Vertical retrace in progress |
| refresh_addr | input | ADDR_W | Live refresh address from the timing generator |
| pen | input | 1 | Light pen strobe, asynchronous |
| cfg_regs | output | NUM_CFG*DW | Timing registers, index k at bits k*DW+:DW |
| cursor_addr | output | ADDR_W | Cursor address for the timing generator |

## Verification
Every cycle, the assertions check the following:
- the pad enable and the zero output when it is off;
- the status bit against `vretrace`, and zero reads of write-only and undefined indexes;
- that a strobe held high never yields a second write pulse;
- that an unselected bus leaves every register still;
- that each pen edge loads exactly the refresh address of that cycle, and nothing else moves the pen register.

Only the bench's scenarios can show the following:
- that the index selects the right register end to end;
- that index bits above IDX_W are dropped;
- that the cursor high part masks its top bits;
- the exact latency from a pen rise to the captured address;
- that a mid-run reset clears state that is later read back over the bus.

// File: rtl/crtc_port_pkg.sv
package crtc_port_pkg;

  // Status bit that mirrors vertical retrace
  localparam int STATUS_VR_BIT = 5;

  typedef enum logic [1:0] {
    ACC_IDLE     = 2'd0,
    ACC_INDEX_WR = 2'd1,
    ACC_REG_WR   = 2'd2,
    ACC_READ     = 2'd3
  } acc_kind_t;

  // Status byte: only the retrace bit is ever set
  function automatic logic [7:0] status_byte(input logic vr);
    logic [7:0] b;
    b = '0;
    b[STATUS_VR_BIT] = vr;
    return b;
  endfunction

  // Classify one bus cycle given the strobe edge
  function automatic acc_kind_t classify(input logic rise, input logic sel_n,
                                         input logic rd, input logic rsel,
                                         input logic strobe);
    if (!sel_n && rd && strobe) return ACC_READ;
    if (rise && !sel_n && !rd) return rsel ? ACC_REG_WR : ACC_INDEX_WR;
    return ACC_IDLE;
  endfunction

endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode #(
  parameter int IDX_W = 5,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rs,
  input  logic             rw,
  input  logic             en,
  input  logic [DW-1:0]    din,
  output logic [IDX_W-1:0] idx,
  output logic             wr_index,
  output logic             wr_reg,
  output logic             rd_active
);
  import crtc_port_pkg::*;

  logic      en_q;
  logic      strobe_rise;
  acc_kind_t kind;

  // Previous strobe level: a write is taken only on a fresh rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign strobe_rise = en & ~en_q;
  assign kind        = classify(strobe_rise, cs_n, rw, rs, en);
  assign wr_index    = (kind == ACC_INDEX_WR);
  assign wr_reg      = (kind == ACC_REG_WR);
  assign rd_active   = (kind == ACC_READ);

  // Index register: upper data bits beyond IDX_W are dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= '0;
    else if (wr_index) idx <= din[IDX_W-1:0];
  end

endmodule

// File: rtl/crtc_port_regs.sv
module crtc_port_regs #(
  parameter int NUM_CFG = 14,
  parameter int ADDR_W  = 14,
  parameter int IDX_W   = 5,
  parameter int DW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_reg,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DW-1:0]         din,
  input  logic [ADDR_W-1:0]     pen_addr,
  output logic [NUM_CFG*DW-1:0] cfg_regs,
  output logic [ADDR_W-1:0]     cursor_addr,
  output logic [DW-1:0]         rd_data
);
  localparam int HI_W = ADDR_W - DW;
  localparam logic [IDX_W-1:0] I_CUR_HI = IDX_W'(NUM_CFG);
  localparam logic [IDX_W-1:0] I_CUR_LO = IDX_W'(NUM_CFG + 1);
  localparam logic [IDX_W-1:0] I_PEN_HI = IDX_W'(NUM_CFG + 2);
  localparam logic [IDX_W-1:0] I_PEN_LO = IDX_W'(NUM_CFG + 3);

  logic [HI_W-1:0] cur_hi;
  logic [DW-1:0]   cur_lo;

  // One storage byte per write-only timing register
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (wr_reg && idx == IDX_W'(g))     q <= din;
    end
    assign cfg_regs[g*DW +: DW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_hi <= '0;
      cur_lo <= '0;
    end else if (wr_reg) begin
      if (idx == I_CUR_HI) cur_hi <= din[HI_W-1:0];
      if (idx == I_CUR_LO) cur_lo <= din;
    end
  end

  assign cursor_addr = {cur_hi, cur_lo};

  // Read mux: write-only and undefined indexes return zero
  always_comb begin
    rd_data = '0;
    case (idx)
      I_CUR_HI: rd_data = DW'(cur_hi);
      I_CUR_LO: rd_data = cur_lo;
      I_PEN_HI: rd_data = DW'(pen_addr[ADDR_W-1:DW]);
      I_PEN_LO: rd_data = pen_addr[DW-1:0];
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/crtc_port_pen.sv
module crtc_port_pen #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pen,
  input  logic [ADDR_W-1:0] refresh_addr,
  output logic              pen_edge,
  output logic [ADDR_W-1:0] pen_addr
);
  logic sync_a, sync_b, sync_c;

  // Two synchronizing flops, then one flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_c <= 1'b0;
    end else begin
      sync_a <= pen;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  assign pen_edge = sync_b & ~sync_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pen_addr <= '0;
    else if (pen_edge) pen_addr <= refresh_addr;
  end

endmodule

// File: rtl/crtc_cpu_port.sv
module crtc_cpu_port #(
  parameter int NUM_CFG = 14,
  parameter int ADDR_W  = 14,
  parameter int IDX_W   = 5,
  parameter int DW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  rs,
  input  logic                  rw,
  input  logic                  en,
  input  logic [DW-1:0]         din,
  output logic [DW-1:0]         dout,
  output logic                  dout_oe,
  input  logic                  vretrace,
  input  logic [ADDR_W-1:0]     refresh_addr,
  input  logic                  pen,
  output logic [NUM_CFG*DW-1:0] cfg_regs,
  output logic [ADDR_W-1:0]     cursor_addr
);
  import crtc_port_pkg::*;

  logic [IDX_W-1:0]  idx_w;
  logic              wr_index;
  logic              wr_reg;
  logic              wr_any;
  logic              rd_active;
  logic              pen_edge;
  logic [ADDR_W-1:0] pen_addr;
  logic [DW-1:0]     rd_data;
  logic [DW-1:0]     stat;

  crtc_port_decode #(.IDX_W(IDX_W), .DW(DW)) u_decode (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rw(rw), .en(en),
    .din(din), .idx(idx_w), .wr_index(wr_index), .wr_reg(wr_reg),
    .rd_active(rd_active)
  );

  crtc_port_regs #(.NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_reg(wr_reg), .idx(idx_w), .din(din),
    .pen_addr(pen_addr), .cfg_regs(cfg_regs), .cursor_addr(cursor_addr),
    .rd_data(rd_data)
  );

  crtc_port_pen #(.ADDR_W(ADDR_W)) u_pen (
    .clk(clk), .rst_n(rst_n), .pen(pen), .refresh_addr(refresh_addr),
    .pen_edge(pen_edge), .pen_addr(pen_addr)
  );

  assign wr_any  = wr_index | wr_reg;
  assign stat    = DW'(status_byte(vretrace));
  assign dout_oe = rd_active;
  assign dout    = rd_active ? (rs ? rd_data : stat) : '0;

endmodule

// File: rtl/crtc_cpu_port_chk.sv
module crtc_cpu_port_chk #(
  parameter int NUM_CFG = 14,
  parameter int ADDR_W  = 14,
  parameter int IDX_W   = 5,
  parameter int DW      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  rs,
  input logic                  rw,
  input logic                  en,
  input logic                  vretrace,
  input logic [DW-1:0]         dout,
  input logic                  dout_oe,
  input logic [NUM_CFG*DW-1:0] cfg_regs,
  input logic [ADDR_W-1:0]     cursor_addr,
  input logic [ADDR_W-1:0]     refresh_addr,
  input logic [IDX_W-1:0]      idx,
  input logic                  wr_pulse,
  input logic                  pen_edge,
  input logic [ADDR_W-1:0]     pen_addr
);
  logic rst_seen;

  a_r1_unselected_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(cursor_addr) && $stable(cfg_regs)));

  a_r2_oe_needs_selected_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !rw || !en) |-> !dout_oe);

  a_r2_quiet_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));

  a_r4_status_retrace: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && !rs) |-> (dout[5] == vretrace && $countones(dout) == (vretrace ? 1 : 0)));

  a_r5_write_only_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && rs && int'(idx) < NUM_CFG) |-> (dout == '0));

  a_r6_single_write_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> !wr_pulse);

  a_r7_cursor_low_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && rs && int'(idx) == NUM_CFG + 1) |-> (dout == cursor_addr[DW-1:0]));

  a_r8_pen_latches_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    pen_edge |=> (pen_addr == $past(refresh_addr)));

  a_r9_pen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pen_edge |=> $stable(pen_addr));

  a_r10_undefined_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && rs && int'(idx) >= NUM_CFG + 4) |-> (dout == '0));

  // R11: one clock after reset is seen low, state must be cleared
  always_ff @(posedge clk) rst_seen <= !rst_n;

  always @(negedge clk) begin
    if (rst_seen && !rst_n) begin
      a_r11_reset_clears: assert (cursor_addr == '0 && cfg_regs == '0 &&
                                  pen_addr == '0 && idx == '0);
    end
  end

endmodule

bind crtc_cpu_port crtc_cpu_port_chk #(
  .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rw(rw), .en(en),
  .vretrace(vretrace), .dout(dout), .dout_oe(dout_oe), .cfg_regs(cfg_regs),
  .cursor_addr(cursor_addr), .refresh_addr(refresh_addr), .idx(idx_w),
  .wr_pulse(wr_any), .pen_edge(pen_edge), .pen_addr(pen_addr)
);

// File: tb/test_crtc_cpu_port.sv
module test_crtc_cpu_port;
  localparam int NUM_CFG = 14;
  localparam int ADDR_W  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rs = 1'b0, rw = 1'b1, en = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;
  logic vretrace = 1'b0;
  logic [ADDR_W-1:0] refresh_addr = '0;
  logic pen = 1'b0;
  logic [NUM_CFG*8-1:0] cfg_regs;
  logic [ADDR_W-1:0] cursor_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  crtc_cpu_port i_crtc_cpu_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rw(rw), .en(en),
    .din(din), .dout(dout), .dout_oe(dout_oe), .vretrace(vretrace),
    .refresh_addr(refresh_addr), .pen(pen), .cfg_regs(cfg_regs),
    .cursor_addr(cursor_addr)
  );

  // {index, write data, expected readback}
  localparam logic [20:0] VEC [8] = '{
    {5'd0,  8'h63, 8'h00}, {5'd1,  8'h50, 8'h00}, {5'd7,  8'h1E, 8'h00},
    {5'd13, 8'hC3, 8'h00}, {5'd14, 8'hFF, 8'h3F}, {5'd15, 8'h81, 8'h81},
    {5'd9,  8'h0F, 8'h00}, {5'd14, 8'h12, 8'h12}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rs = sel; rw = 1'b0; din = d; en = 1'b1;
    @(negedge clk);
    en = 1'b0; cs_n = 1'b1; rw = 1'b1;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rs = sel; rw = 1'b1; en = 1'b1;
    #1;
    d = dout; oe = dout_oe;
    en = 1'b0; cs_n = 1'b1;
  endtask

  task automatic read_idx(input logic [7:0] i, output logic [7:0] d);
    logic oe;
    bus_write(1'b0, i);
    bus_read(1'b1, d, oe);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic oe;
    logic [ADDR_W-1:0] cur_snap;
    logic [NUM_CFG*8-1:0] cfg_snap;

    repeat (3) @(negedge clk);
    chk(cfg_regs == '0, "R11 cfg after reset", cfg_regs[31:0], 0);
    chk(cursor_addr == '0, "R11 cursor after reset", cursor_addr, 0);
    chk(dout_oe == 1'b0, "R2 oe idle", dout_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: index, write, read back
    for (int i = 0; i < 8; i++) begin
      bus_write(1'b0, {3'b0, VEC[i][20:16]});
      bus_write(1'b1, VEC[i][15:8]);
      bus_read(1'b1, d, oe);
      chk(d == VEC[i][7:0] && oe, "R5 R7 readback", d, VEC[i][7:0]);
      if (VEC[i][20:16] < 5'd14)
        chk(cfg_regs[VEC[i][20:16]*8 +: 8] == VEC[i][15:8], "R5 cfg field",
            cfg_regs[VEC[i][20:16]*8 +: 8], VEC[i][15:8]);
    end
    chk(cursor_addr == 14'h1281, "R7 cursor_addr", cursor_addr, 14'h1281);

    // R3: index bits above width dropped (0x2E -> 14)
    bus_write(1'b0, 8'h2E);
    bus_write(1'b1, 8'h05);
    @(negedge clk);
    chk(cursor_addr == 14'h0581, "R3 index truncation", cursor_addr, 14'h0581);

    // R4: status byte
    vretrace = 1'b1;
    bus_read(1'b0, d, oe);
    chk(d == 8'h20, "R4 status retrace", d, 8'h20);
    vretrace = 1'b0;
    bus_read(1'b0, d, oe);
    chk(d == 8'h00, "R4 status idle", d, 8'h00);

    // R1: deselected write and read
    bus_write(1'b0, 8'd15);
    cur_snap = cursor_addr;
    @(negedge clk);
    cs_n = 1'b1; rs = 1'b1; rw = 1'b0; din = 8'h99; en = 1'b1;
    @(negedge clk);
    en = 1'b0; rw = 1'b1;
    @(negedge clk);
    chk(cursor_addr == cur_snap, "R1 deselected write", cursor_addr, cur_snap);
    @(negedge clk);
    cs_n = 1'b1; rs = 1'b1; rw = 1'b1; en = 1'b1;
    #1;
    chk(dout_oe == 1'b0 && dout == '0, "R1 R2 deselected read", {dout_oe, dout}, 0);
    en = 1'b0;

    // R6: held strobe writes once; long idle harmless
    @(negedge clk);
    cs_n = 1'b0; rs = 1'b1; rw = 1'b0; din = 8'h11; en = 1'b1;
    repeat (2) @(negedge clk);
    din = 8'h77;
    repeat (2) @(negedge clk);
    en = 1'b0; cs_n = 1'b1; rw = 1'b1;
    bus_read(1'b1, d, oe);
    chk(d == 8'h11, "R6 held strobe", d, 8'h11);
    repeat (20) @(negedge clk);
    bus_read(1'b1, d, oe);
    chk(d == 8'h11, "R6 idle strobe", d, 8'h11);
    bus_write(1'b1, 8'h22);
    bus_read(1'b1, d, oe);
    chk(d == 8'h22, "R6 next strobe", d, 8'h22);

    // R8: pen capture
    @(negedge clk);
    refresh_addr = 14'h2A5B; pen = 1'b1;
    repeat (5) @(negedge clk);
    refresh_addr = 14'h0111;
    read_idx(8'd16, d);
    chk(d == 8'h2A, "R8 pen high", d, 8'h2A);
    read_idx(8'd17, d);
    chk(d == 8'h5B, "R8 pen low", d, 8'h5B);

    // R9: falling and steady pen
    pen = 1'b0;
    repeat (5) @(negedge clk);
    refresh_addr = 14'h3C3C;
    repeat (5) @(negedge clk);
    read_idx(8'd17, d);
    chk(d == 8'h5B, "R9 pen held", d, 8'h5B);

    // R10: write to read-only pen index ignored
    bus_write(1'b1, 8'hEE);
    bus_read(1'b1, d, oe);
    chk(d == 8'h5B, "R10 pen write ignored", d, 8'h5B);

    // R10: undefined index
    cfg_snap = cfg_regs;
    cur_snap = cursor_addr;
    bus_write(1'b0, 8'd20);
    bus_write(1'b1, 8'hAA);
    bus_read(1'b1, d, oe);
    chk(d == 8'h00, "R10 undefined read", d, 0);
    chk(cfg_regs == cfg_snap && cursor_addr == cur_snap, "R10 undefined write",
        cursor_addr, cur_snap);

    // R8: second rise captures new address
    pen = 1'b1;
    repeat (5) @(negedge clk);
    read_idx(8'd16, d);
    chk(d == 8'h3C, "R8 second capture", d, 8'h3C);

    // R11: mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cursor_addr == '0 && cfg_regs == '0, "R11 mid-run reset", cursor_addr, 0);
    pen = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    read_idx(8'd17, d);
    chk(d == 8'h00, "R11 pen cleared", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule